// File: doc/BRIEF.md
# Sigma-Delta Bridge Driver

This block turns a held 8-bit two's complement audio sample into a 1-bit pulse-density stream. The stream advances once per master clock, so the master clock sets the output sampling rate. A first-order error-feedback modulator does the conversion. The modulator's bit drives two complementary outputs that feed the two sides of a bridge load. One side carries the bit and the other side carries its inverse, which doubles the swing across the load.

A new sample is taken only on a one-cycle load strobe. It is reproduced for as long as no further strobe arrives, which gives zero-order hold interpolation between updates. While the synchronous reset is high, the block is in power-down:
- both bridge outputs are driven low, so no DC bias sits across the load;
- the held sample is cleared;
- the accumulator returns to its midpoint.

Top module: `sdm_bridge_driver`

## Requirements
- R1: On every clock edge that samples `rst` high, both `out_pos` and `out_neg` become 0 and stay 0 until the next edge at which `rst` is low.
- R2: After reset, the held sample is zero and the accumulator holds its midpoint, 128. At the first edge with `rst` low, `out_pos` becomes 1. It then alternates 0, 1, 0, … while no load arrives.
- R3: After any edge with `rst` low, `out_neg` equals the inverse of `out_pos`.
- R4: `sample` is captured only at an edge where `load` is 1 and `rst` is 0. Changes on `sample` while `load` is 0 have no effect on the outputs.
- R5: A sample captured at edge k first influences the output bit produced at edge k+1.
- R6: A held sample of 0x00 produces a strictly alternating bit stream, which is an exact 50% density.
- R7: The sample is mapped to a level by inverting its most significant bit (offset binary). Over any 256 consecutive edges with the same held sample, `out_pos` is 1 exactly `level` times.
- R8: A held sample of 0x80 (most negative) gives `out_pos` = 0 on every edge. A held sample of 0x7F (most positive) gives 255 ones in every 256 edges.
- R9: A `load` strobe at an edge where `rst` is high is ignored, and the held sample stays zero.
- R10: At each edge with `rst` low, the 9-bit sum of the accumulator and the level is formed. Its carry, bit 8, becomes `out_pos`, and its low 8 bits become the new accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one output bit per edge |
| rst | input | 1 | Synchronous active-high reset / power-down |
| load | input | 1 | One-cycle strobe that captures `sample` |
| sample | input | 8 | Two's complement audio sample |
| out_pos | output | 1 | Bridge side carrying the modulated bit |
| out_neg | output | 1 | Bridge side carrying the inverted bit |

## Verification
Several properties are checked by assertions on every cycle:
- the power-down low level on both outputs (R1);
- the complementary relation between the outputs (R3);
- capture on the strobe and hold without it (R4);
- strict alternation for a held zero sample (R6).

The exact bit sequence, the restart from the accumulator midpoint, and the density over a 256-cycle window for chosen levels can only be shown by the bench scenarios. The bench runs each of these against an independent model of the error-feedback arithmetic.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int SAMPLE_W = 8;

    typedef struct packed {
        logic pos;
        logic neg;
    } legs_t;

    localparam legs_t LEGS_OFF = '{pos: 1'b0, neg: 1'b0};

    function automatic legs_t bridge_legs(input logic bit_i);
        legs_t l;
        l.pos = bit_i;
        l.neg = ~bit_i;
        return l;
    endfunction

endpackage

// File: rtl/sdm_sample_hold.sv
module sdm_sample_hold #(
    parameter int W = sdm_pkg::SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] held_o
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)       held_q <= '0;
        else if (load) held_q <= sample_i;
    end

    assign held_o = held_q;

    // R4: value persists without a strobe
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held_q));

    // R4: strobe captures the bus value
    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> held_q == $past(sample_i));

endmodule

// File: rtl/sdm_modulator.sv
module sdm_modulator #(
    parameter int W = sdm_pkg::SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] held_i,
    output logic         bit_o
);

    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] acc_q;
    logic [W-1:0] level;
    logic [W:0]   sum;

    always_comb begin
        level = {~held_i[W-1], held_i[W-2:0]};
        sum   = {1'b0, acc_q} + {1'b0, level};
        bit_o = sum[W];
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= MID;
        else     acc_q <= sum[W-1:0];
    end

    // R6: a zero sample held for two cycles gives alternating bits
    assert_zero_alternates_R6: assert property (@(posedge clk) disable iff (rst)
        (held_i == '0 && $past(held_i) == '0 && !$past(rst)) |-> bit_o != $past(bit_o));

endmodule

// File: rtl/sdm_bridge_out.sv
module sdm_bridge_out
    import sdm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_i,
    output legs_t legs_o
);

    legs_t legs_q;

    always_ff @(posedge clk) begin
        if (rst) legs_q <= LEGS_OFF;
        else     legs_q <= bridge_legs(bit_i);
    end

    assign legs_o = legs_q;

    // R1: power-down drives both sides low
    assert_pd_low_R1: assert property (@(posedge clk)
        rst |=> (!legs_q.pos && !legs_q.neg));

    // R3: running output is a complementary pair
    assert_complement_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (legs_q.pos != legs_q.neg));

endmodule

// File: rtl/sdm_bridge_driver.sv
module sdm_bridge_driver #(
    parameter int W = sdm_pkg::SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] sample,
    output logic         out_pos,
    output logic         out_neg
);

    sdm_pkg::legs_t legs;
    logic [W-1:0]   held;
    logic           mod_bit;

    sdm_sample_hold #(.W(W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .sample_i (sample),
        .held_o   (held)
    );

    sdm_modulator #(.W(W)) u_mod (
        .clk    (clk),
        .rst    (rst),
        .held_i (held),
        .bit_o  (mod_bit)
    );

    sdm_bridge_out u_out (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (mod_bit),
        .legs_o (legs)
    );

    assign out_pos = legs.pos;
    assign out_neg = legs.neg;

endmodule

// File: tb/sim_sdm_bridge_driver.sv
`timescale 1ns/1ps
module sim_sdm_bridge_driver;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] sample = 8'h00;
    logic       out_pos, out_neg;

    always #4 clk = ~clk;

    sdm_bridge_driver u0 (
        .clk(clk), .rst(rst), .load(load), .sample(sample),
        .out_pos(out_pos), .out_neg(out_neg)
    );

    int compared   = 0;
    int mismatched = 0;
    int ones_cnt   = 0;
    bit finished   = 0;

    logic  q_pos[$];
    logic  q_neg[$];
    string q_tag[$];

    int m_acc  = 128;
    int m_held = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: apply inputs for the next edge and push the model's result
    task automatic step(input bit r, input bit ld, input logic [7:0] s, input string tag);
        int lvl, sm;
        @(negedge clk);
        rst = r; load = ld; sample = s;
        if (r) begin
            q_pos.push_back(1'b0); q_neg.push_back(1'b0);
            m_acc = 128; m_held = 0;
        end else begin
            lvl = m_held ^ 128;
            sm  = m_acc + lvl;
            q_pos.push_back(sm >= 256); q_neg.push_back(sm < 256);
            m_acc = sm % 256;
            if (ld) m_held = s;
        end
        q_tag.push_back(tag);
        @(posedge clk);
        #3;
    endtask

    // monitor: compare each produced pair against the queue
    always @(posedge clk) begin
        #2;
        if (q_pos.size() > 0) begin
            logic ep, en;
            string t;
            ep = q_pos.pop_front(); en = q_neg.pop_front(); t = q_tag.pop_front();
            check(out_pos === ep && out_neg === en, t,
                  {30'd0, out_pos, out_neg}, {30'd0, ep, en});
            if (out_pos === 1'b1) ones_cnt++;
        end
    end

    task automatic density(input logic [7:0] s, input string tag, input int exp_ones);
        int base;
        step(0, 1, s, tag);
        base = ones_cnt;
        for (int i = 0; i < 256; i++)
            step(0, 0, s ^ i[7:0], tag);   // bus wiggles while load low (R4)
        check(ones_cnt - base == exp_ones, tag, ones_cnt - base, exp_ones);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr = 8'h5A;
        // R1: reset state
        repeat (3) step(1, 0, 8'h00, "R1");
        // R2: release from midpoint with zero sample: 1,0,1,0
        for (int i = 0; i < 6; i++) step(0, 0, 8'h00, "R2");
        // R9: strobe during reset ignored
        step(1, 1, 8'h55, "R9");
        for (int i = 0; i < 6; i++) step(0, 0, 8'h33, "R9");
        // R4 / R5: capture and one-cycle latency
        step(0, 1, 8'h40, "R5");
        for (int i = 0; i < 8; i++) step(0, 0, 8'hFF, "R4");
        step(0, 1, 8'hE0, "R5");
        for (int i = 0; i < 8; i++) step(0, 0, 8'h01, "R4");
        // densities
        density(8'h00, "R6", 128);
        density(8'h80, "R8", 0);
        density(8'h7F, "R8", 255);
        density(8'hC0, "R7", 64);
        density(8'h20, "R7", 160);
        // R10 / R3: changing samples every few cycles
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(0, (i % 3) == 0, lfsr, "R10");
        end
        // R1 mid-stream, then R2 restart
        step(0, 1, 8'h70, "R3");
        repeat (2) step(1, 0, 8'h70, "R1");
        for (int i = 0; i < 6; i++) step(0, 0, 8'h00, "R2");
        @(posedge clk); #3;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule